// File: doc/BRIEF.md
# Bus Transceiver Operating Mode Controller

This block is the digital mode controller of a single-channel automotive bus transceiver. It keeps the current operating mode: normal, receive-only, standby, go-to-sleep or sleep. It drives the regulator-enable output that the mode implies, and it works out the symbol the line transmitter must drive. The host picks a mode through two level pins. Host requests are accepted only after both pins have held their levels for a programmable filter time. Go-to-sleep is a transit state that runs out into sleep after a programmable time.

Three supply undervoltage indications take priority over the host pins, and so does a wake event. The undervoltage inputs are already filtered, and each arrives as a level. A new battery-side or I/O-side undervoltage forces sleep. A new core-supply undervoltage forces standby unless the block is already asleep. A wake event clears every latched undervoltage flag and forces standby, after which the pins take control again.

In normal mode the transmit path follows the enable, guard and data inputs. A transmission must begin with a dominant-low symbol. A transmit enable that stays active for too long is cut off by a timeout flag. Every input passes through a two-flop synchroniser.

Top module: `bus_xcvr_mode_ctrl`

## Requirements
- R1: The synchronised pins select the mode, reported on `modeOut` as normal=0, receive-only=1, standby=2, go-to-sleep=3, sleep=4. The pin decode is: stbn=1,en=1 selects normal; stbn=1,en=0 selects receive-only; stbn=0,en=0 selects standby; stbn=0,en=1 selects go-to-sleep. A go-to-sleep request made while in sleep leaves the block in sleep.
- R2: A pin request takes effect only after both synchronised pins have been stable for FILT_CYC cycles. A pulse shorter than that leaves the mode unchanged.
- R3: Once go-to-sleep has lasted GTS_CYC cycles, the mode becomes sleep.
- R4: A rising battery or I/O undervoltage input forces sleep. While either latched flag is set, the pins are ignored. When the input falls, the flag clears and pin control resumes.
- R5: A rising core-supply undervoltage input forces standby when not in sleep, and leaves sleep unchanged. While the flag is set, the pins are ignored.
- R6: A wake event clears all undervoltage flags and forces standby. This holds even when a wake event and a new undervoltage arrive in the same cycle. Pin control then resumes after the filter time.
- R7: `inhOut` is 1 in every mode except sleep, where it is 0.
- R8: `txCodeOut` uses the encoding idle_lp=0, idle=1, data_0=2, data_1=3. The code is idle_lp in standby, go-to-sleep and sleep, and idle in receive-only. In normal mode it is idle when bge=0 or txen=1; otherwise it follows txd (0 gives data_0, 1 gives data_1).
- R9: After idle, the first active symbol is data_0. While txd=1 and no transmission has begun, the code stays idle.
- R10: If txen stays low in normal mode for TXMAX_CYC cycles, `txTimeout` is set and the code is forced to idle. The flag clears when txen goes high or when normal mode is left.
- R11: After reset the mode is standby, `inhOut`=1, `txTimeout`=0, `txCodeOut`=idle_lp and `powerOnFlag`=1. `powerOnFlag` clears when normal mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stbnPin | input | 1 | Host mode pin, standby-not |
| enPin | input | 1 | Host mode pin, enable |
| uvBatIn | input | 1 | Filtered battery undervoltage |
| uvVccIn | input | 1 | Filtered core-supply undervoltage |
| uvIoIn | input | 1 | Filtered I/O-supply undervoltage |
| wakeIn | input | 1 | Wake event (local or remote) |
| txenPin | input | 1 | Transmit enable, active low |
| bgePin | input | 1 | Bus guardian enable, active high |
| txdPin | input | 1 | Transmit data |
| modeOut | output | 3 | Current mode code |
| inhOut | output | 1 | Regulator enable |
| txCodeOut | output | 2 | Transmitter symbol code |
| txTimeout | output | 1 | Transmit enable timeout flag |
| powerOnFlag | output | 1 | Power-on flag |

## Verification
The bench provokes two same-cycle collisions. In the first, a wake event and a fresh battery undervoltage are driven on the same clock edge. The mode must land in standby, not sleep, and it must return to normal later while the undervoltage input is still high, which shows that the flag really was cleared. In the second, the timeout flag is set while normal mode is being left. Both the flag and the code must read as cleared and idle once receive-only is reached.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_RXONLY  = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_GOSLEEP = 3'd3,
    MODE_SLEEP   = 3'd4
  } mode_t;

  typedef enum logic [1:0] {
    TX_IDLE_LP = 2'd0,
    TX_IDLE    = 2'd1,
    TX_DATA0   = 2'd2,
    TX_DATA1   = 2'd3
  } tx_code_t;

  typedef struct packed {
    logic normal;
    logic rxOnly;
    logic lowPower;
  } ctrl_strobe_t;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
#(
  parameter int FILT_CYC = 2000,
  parameter int GTS_CYC  = 1200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stbn,
  input  logic         en,
  input  logic         uvBat,
  input  logic         uvVcc,
  input  logic         uvIo,
  input  logic         wake,
  output mode_t        mode,
  output logic         inh,
  output logic         powerOn,
  output ctrl_strobe_t strb
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int GW = $clog2(GTS_CYC + 1);

  mode_t       modeR, modeNext, pinMode;
  logic [1:0]  pinsPrev;
  logic [FW-1:0] filtCnt;
  logic [GW-1:0] gtsCnt;
  logic        batPrev, vccPrev, ioPrev;
  logic        batFlag, vccFlag, ioFlag;
  logic        batSet, vccSet, ioSet, anyUv, pinStable, gtsDone;
  logic        inhR, powerOnR;

  assign batSet    = uvBat && !batPrev;
  assign vccSet    = uvVcc && !vccPrev;
  assign ioSet     = uvIo  && !ioPrev;
  assign anyUv     = batFlag || vccFlag || ioFlag;
  assign pinStable = (filtCnt == FW'(FILT_CYC));
  assign gtsDone   = (gtsCnt == GW'(GTS_CYC - 1));

  always_comb begin
    unique case ({stbn, en})
      2'b11:   pinMode = MODE_NORMAL;
      2'b10:   pinMode = MODE_RXONLY;
      2'b00:   pinMode = MODE_STANDBY;
      default: pinMode = MODE_GOSLEEP;
    endcase
  end

  always_comb begin
    modeNext = modeR;
    if (wake)
      modeNext = MODE_STANDBY;
    else if (batSet || ioSet)
      modeNext = MODE_SLEEP;
    else if (vccSet && modeR != MODE_SLEEP)
      modeNext = MODE_STANDBY;
    else if (anyUv || vccSet)
      modeNext = modeR;
    else if (modeR == MODE_GOSLEEP && gtsDone)
      modeNext = MODE_SLEEP;
    else if (pinStable && pinMode != modeR &&
             !(modeR == MODE_SLEEP && pinMode == MODE_GOSLEEP))
      modeNext = pinMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeR    <= MODE_STANDBY;
      pinsPrev <= 2'b00;
      filtCnt  <= '0;
      gtsCnt   <= '0;
      batPrev  <= 1'b0;
      vccPrev  <= 1'b0;
      ioPrev   <= 1'b0;
      batFlag  <= 1'b0;
      vccFlag  <= 1'b0;
      ioFlag   <= 1'b0;
      inhR     <= 1'b1;
      powerOnR <= 1'b1;
    end else begin
      modeR    <= modeNext;
      pinsPrev <= {stbn, en};
      if (wake || pinsPrev != {stbn, en})
        filtCnt <= '0;
      else if (!pinStable)
        filtCnt <= filtCnt + 1'b1;
      gtsCnt  <= (modeR == MODE_GOSLEEP && !gtsDone) ? gtsCnt + 1'b1 : '0;
      batPrev <= uvBat;
      vccPrev <= uvVcc;
      ioPrev  <= uvIo;
      batFlag <= !wake && (batSet || (batFlag && uvBat));
      vccFlag <= !wake && (vccSet || (vccFlag && uvVcc));
      ioFlag  <= !wake && (ioSet  || (ioFlag  && uvIo));
      inhR    <= (modeNext != MODE_SLEEP);
      if (modeNext == MODE_NORMAL) powerOnR <= 1'b0;
    end
  end

  assign mode          = modeR;
  assign inh           = inhR;
  assign powerOn       = powerOnR;
  assign strb.normal   = (modeR == MODE_NORMAL);
  assign strb.rxOnly   = (modeR == MODE_RXONLY);
  assign strb.lowPower = (modeR == MODE_STANDBY) || (modeR == MODE_GOSLEEP) ||
                         (modeR == MODE_SLEEP);

  assert_inh_follows_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inhR == (modeR != MODE_SLEEP));

  assert_uv_holds_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (batFlag || ioFlag) |-> modeR == MODE_SLEEP);

  assert_vcc_forces_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vccSet && !wake && !batSet && !ioSet && modeR != MODE_SLEEP)
      |=> modeR == MODE_STANDBY);

  assert_wake_to_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (modeR == MODE_STANDBY && !batFlag && !vccFlag && !ioFlag));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (modeR == MODE_GOSLEEP && gtsDone && !wake && !anyUv && !vccSet)
      |=> modeR == MODE_SLEEP);
endmodule

// File: rtl/xcvr_tx_path.sv
module xcvr_tx_path
  import xcvr_mode_pkg::*;
#(
  parameter int TXMAX_CYC = 75000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_strobe_t strb,
  input  logic         txen,
  input  logic         bge,
  input  logic         txd,
  output tx_code_t     txCode,
  output logic         txTimeout
);
  localparam int TW = $clog2(TXMAX_CYC);

  logic [TW-1:0] lowCnt;
  logic          toR, toNext, lowActive, enabled, activeR, activeNext;
  tx_code_t      codeR, codeNext;

  assign lowActive = strb.normal && !txen;
  assign toNext    = lowActive && (toR || lowCnt == TW'(TXMAX_CYC - 1));
  assign enabled   = strb.normal && bge && !txen && !toNext;

  always_comb begin
    activeNext = 1'b0;
    if (strb.lowPower)
      codeNext = TX_IDLE_LP;
    else if (!enabled)
      codeNext = TX_IDLE;
    else if (activeR) begin
      codeNext   = txd ? TX_DATA1 : TX_DATA0;
      activeNext = 1'b1;
    end else if (!txd) begin
      codeNext   = TX_DATA0;
      activeNext = 1'b1;
    end else
      codeNext = TX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt  <= '0;
      toR     <= 1'b0;
      activeR <= 1'b0;
      codeR   <= TX_IDLE_LP;
    end else begin
      if (!lowActive)
        lowCnt <= '0;
      else if (lowCnt != TW'(TXMAX_CYC - 1))
        lowCnt <= lowCnt + 1'b1;
      toR     <= toNext;
      activeR <= activeNext;
      codeR   <= codeNext;
    end
  end

  assign txCode    = codeR;
  assign txTimeout = toR;

  assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    toR |-> (codeR == TX_IDLE || codeR == TX_IDLE_LP));

  assert_timeout_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.normal || txen) |=> !toR);

  assert_low_power_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lowPower |=> codeR == TX_IDLE_LP);

  assert_first_data0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(codeR) != TX_DATA0 && $past(codeR) != TX_DATA1 && codeR == TX_DATA1)
      |-> 1'b0);
endmodule

// File: rtl/bus_xcvr_mode_ctrl.sv
module bus_xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int FILT_CYC  = 2000,
  parameter int GTS_CYC   = 1200,
  parameter int TXMAX_CYC = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stbnPin,
  input  logic       enPin,
  input  logic       uvBatIn,
  input  logic       uvVccIn,
  input  logic       uvIoIn,
  input  logic       wakeIn,
  input  logic       txenPin,
  input  logic       bgePin,
  input  logic       txdPin,
  output logic [2:0] modeOut,
  output logic       inhOut,
  output logic [1:0] txCodeOut,
  output logic       txTimeout,
  output logic       powerOnFlag
);
  localparam int NIN = 9;

  logic [NIN-1:0] rawIn, syncIn;
  mode_t          mode;
  tx_code_t       txCode;
  ctrl_strobe_t   strb;

  assign rawIn = {stbnPin, enPin, uvBatIn, uvVccIn, uvIoIn, wakeIn,
                  txenPin, bgePin, txdPin};

  xcvr_sync #(.WIDTH(NIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(rawIn), .syncOut(syncIn)
  );

  xcvr_mode_fsm #(.FILT_CYC(FILT_CYC), .GTS_CYC(GTS_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .stbn(syncIn[8]), .en(syncIn[7]),
    .uvBat(syncIn[6]), .uvVcc(syncIn[5]), .uvIo(syncIn[4]), .wake(syncIn[3]),
    .mode(mode), .inh(inhOut), .powerOn(powerOnFlag), .strb(strb)
  );

  xcvr_tx_path #(.TXMAX_CYC(TXMAX_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .txen(syncIn[2]), .bge(syncIn[1]), .txd(syncIn[0]),
    .txCode(txCode), .txTimeout(txTimeout)
  );

  assign modeOut   = mode;
  assign txCodeOut = txCode;
endmodule

// File: tb/tb_bus_xcvr_mode_ctrl.sv
module tb_bus_xcvr_mode_ctrl;
  localparam int FILT  = 16;
  localparam int GTS   = 24;
  localparam int TXMAX = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stbnPin = 0, enPin = 0, uvBatIn = 0, uvVccIn = 0, uvIoIn = 0, wakeIn = 0;
  logic txenPin = 1, bgePin = 0, txdPin = 1;
  logic [2:0] modeOut;
  logic inhOut, txTimeout, powerOnFlag;
  logic [1:0] txCodeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_xcvr_mode_ctrl #(.FILT_CYC(FILT), .GTS_CYC(GTS), .TXMAX_CYC(TXMAX)) dut (
    .clk(clk), .rst_n(rst_n), .stbnPin(stbnPin), .enPin(enPin),
    .uvBatIn(uvBatIn), .uvVccIn(uvVccIn), .uvIoIn(uvIoIn), .wakeIn(wakeIn),
    .txenPin(txenPin), .bgePin(bgePin), .txdPin(txdPin),
    .modeOut(modeOut), .inhOut(inhOut), .txCodeOut(txCodeOut),
    .txTimeout(txTimeout), .powerOnFlag(powerOnFlag)
  );

  function automatic int expMode(input logic s, input logic e);
    return s ? (e ? 0 : 1) : (e ? 3 : 2);
  endfunction

  function automatic int expTx(input logic bge, input logic txen, input logic txd,
                               input bit active);
    if (!bge || txen) return 1;
    if (active) return txd ? 3 : 2;
    return txd ? 1 : 2;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    step(200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit active;
    int lowRun;
    void'($urandom(32'd4711));
    step(5);
    rst_n = 1'b1;
    step(2);
    // R11 reset state
    chk("R11 mode", modeOut, 2);
    chk("R11 inh", inhOut, 1);
    chk("R11 powerOn", powerOnFlag, 1);
    chk("R11 timeout", txTimeout, 0);
    chk("R11 txCode", txCodeOut, 0);

    // R2 filter, R1 normal
    stbnPin = 1; enPin = 1;
    step(FILT - 4);
    chk("R2 not yet", modeOut, 2);
    step(12);
    chk("R1 normal", modeOut, expMode(1, 1));
    chk("R11 powerOn cleared", powerOnFlag, 0);
    enPin = 0; step(3); enPin = 1;
    step(FILT + 8);
    chk("R2 glitch ignored", modeOut, 0);

    // R8 / R9 directed
    bgePin = 1; txenPin = 1; txdPin = 1; step(6);
    chk("R8 txen high idle", txCodeOut, 1);
    txenPin = 0; step(6);
    chk("R9 no start on data_1", txCodeOut, 1);
    txdPin = 0; step(6);
    chk("R9 start data_0", txCodeOut, 2);
    txdPin = 1; step(6);
    chk("R8 data_1", txCodeOut, 3);
    bgePin = 0; step(6);
    chk("R8 bge low idle", txCodeOut, 1);
    txenPin = 1; bgePin = 1; step(6);

    // R8 / R9 random
    active = 0; lowRun = 0;
    for (int i = 0; i < 60; i++) begin
      bgePin  = $urandom_range(0, 3) != 0;
      txdPin  = $urandom_range(0, 1);
      txenPin = (lowRun >= 4) ? 1'b1 : ($urandom_range(0, 2) == 0);
      lowRun  = txenPin ? 0 : lowRun + 1;
      step(5);
      chk("R8 random tx code", txCodeOut, expTx(bgePin, txenPin, txdPin, active));
      active = (bgePin && !txenPin) && (active || !txdPin);
    end

    // R10 timeout
    txenPin = 1; step(6);
    bgePin = 1; txdPin = 0; txenPin = 0; step(6);
    chk("R9 data_0 before timeout", txCodeOut, 2);
    step(TXMAX + 6);
    chk("R10 timeout set", txTimeout, 1);
    chk("R10 forced idle", txCodeOut, 1);
    txenPin = 1; step(6);
    chk("R10 cleared by txen", txTimeout, 0);
    txenPin = 0; step(TXMAX + 10);
    chk("R10 set again", txTimeout, 1);
    enPin = 0; step(FILT + 8);
    chk("R1 rx-only", modeOut, expMode(1, 0));
    chk("R10 cleared leaving normal", txTimeout, 0);
    chk("R8 rx-only idle", txCodeOut, 1);

    // standby, go-to-sleep, sleep
    stbnPin = 0; step(FILT + 8);
    chk("R1 standby", modeOut, 2);
    chk("R8 standby idle_lp", txCodeOut, 0);
    chk("R7 standby inh", inhOut, 1);
    enPin = 1; step(FILT + 8);
    chk("R1 go-to-sleep", modeOut, 3);
    chk("R7 go-to-sleep inh", inhOut, 1);
    step(GTS + 6);
    chk("R3 sleep after timeout", modeOut, 4);
    chk("R7 sleep inh", inhOut, 0);
    step(FILT + 8);
    chk("R1 sleep holds on go-to-sleep pins", modeOut, 4);
    stbnPin = 1; step(FILT + 8);
    chk("R1 sleep to normal", modeOut, 0);

    // R4 battery undervoltage, R6 wake
    uvBatIn = 1; step(6);
    chk("R4 bat forces sleep", modeOut, 4);
    stbnPin = 0; enPin = 0; step(FILT + 8);
    chk("R4 pins ignored", modeOut, 4);
    wakeIn = 1; step(3); wakeIn = 0; step(4);
    chk("R6 wake standby", modeOut, 2);
    chk("R6 inh", inhOut, 1);
    stbnPin = 1; enPin = 1; step(FILT + 8);
    chk("R6 pin control resumes", modeOut, 0);
    uvBatIn = 0; step(4);

    // R5 core-supply undervoltage
    uvVccIn = 1; step(6);
    chk("R5 vcc forces standby", modeOut, 2);
    step(FILT + 8);
    chk("R5 pins ignored", modeOut, 2);
    uvVccIn = 0; step(8);
    chk("R5 recovery", modeOut, 0);
    uvIoIn = 1; step(6);
    chk("R4 io forces sleep", modeOut, 4);
    uvVccIn = 1; step(6);
    chk("R5 sleep kept", modeOut, 4);
    uvIoIn = 0; uvVccIn = 0; step(FILT + 8);
    chk("R4 recovery", modeOut, 0);

    // R6 collision: wake and new undervoltage together
    uvBatIn = 1; wakeIn = 1; step(3); wakeIn = 0; step(4);
    chk("R6 wake wins collision", modeOut, 2);
    step(FILT + 8);
    chk("R6 flag cleared", modeOut, 0);
    uvBatIn = 0; step(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule